// File: doc/BRIEF.md
# Single-Wire Slave Transaction Framer

This block is the slave-side frame parser for a single-wire, pulse-width-coded sensor bus. A symbol transceiver below it measures how long the line is held low and turns each pulse into a one-cycle symbol strobe. This block takes those strobes and tracks each frame: a Start symbol, then the device number, the register number, the direction bit, the data bits, an even-parity bit and an acknowledge bit. It compares the device number against its own number, which comes from two strap inputs, and against the broadcast number. For a write addressed to it, it collects the data and commits it to the register file once a positive acknowledge ends the frame. For a read, it captures the register value once and hands the data bits and the parity bit back to the transceiver one at a time.

The transceiver uses the `reply_one` level to decide whether to stretch the bit that the master is starting into a one. The framer holds no register contents and does not define what any status flag means. It only reports a bus error when a frame ends with a negative acknowledge.

Top module: `swd_frame_slave`

## Requirements
- R1: Symbol codes on `sym_code` are 0 = zero bit, 1 = one bit, 2 = Start, 3 = attention, 4 = reset. After a Start, the frame carries a 3-bit device number, a 6-bit register number, a direction bit (1 = read, 0 = write), the data, a parity bit and an acknowledge bit. Every field is sent most significant bit first, and `reg_addr` shows the received register number.
- R2: Registers 0x00, 0x04 and 0x20 carry 8 data bits and every other register carries 16. An 8-bit write shows the value zero-extended on `reg_wdata`. An 8-bit read sends bits 7:0 of `reg_rdata`.
- R3: During the acknowledge slot of a write to this device, `reply_one` is 1 exactly when the bits from the device number through the parity bit hold an even number of ones.
- R4: A write commits through a single-cycle `reg_we` pulse, with `reg_addr` and `reg_wdata` valid, one cycle after the acknowledge strobe. This happens only when the parity is even and the acknowledge is observed as a one.
- R5: `bus_err` pulses one cycle after the acknowledge strobe of a frame this device takes part in, when that acknowledge is zero. For a write this covers bad parity and an acknowledge observed as zero. For a read it covers a zero acknowledge from the master.
- R6: For a read addressed to this device, `reg_re` is high during the strobe of the direction bit, and the register value is captured on that edge. Before each later data bit and before the parity bit, `reply_one` gives the next data bit, MSB first, and then the bit that makes the parity even.
- R7: The device's own number is the strap value plus one, resampled at every Start. A frame carrying any other non-zero number causes no reply, no strobe and no error. It is still followed to its end.
- R8: A broadcast (device 0) read is ignored. A broadcast write to register 0x05 commits with `reg_bcast` = 1. A broadcast write to any other register is ignored.
- R9: A Start in the middle of a frame drops that frame and begins a new one without an error. A reset symbol drops the frame, and data symbols are then ignored until the next Start. Attention symbols are not counted as bits.
- R10: Bit symbols arriving after the acknowledge are ignored until the next Start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | One-cycle strobe for a decoded symbol |
| sym_code | input | 3 | Symbol code (see R1) |
| strap | input | 2 | Address straps; own number = strap + 1 |
| reg_addr | output | 6 | Register number of the current frame |
| reg_rdata | input | 16 | Register-file read data for `reg_addr` |
| reg_re | output | 1 | Read strobe, high while the direction bit is taken |
| reg_we | output | 1 | Write commit pulse |
| reg_bcast | output | 1 | The committed write was a broadcast |
| reg_wdata | output | 16 | Write data, valid with `reg_we` |
| reply_one | output | 1 | Ask the transceiver to stretch the next bit to a one |
| bus_err | output | 1 | Negative-acknowledge pulse |

## Verification
The bench targets the places where the bit positions shift. It uses 8-bit and 16-bit registers in both directions. If the length decode were wrong, the acknowledge slot would be misplaced, and the expected `reg_we` or `bus_err` would appear a slot early or late, or not at all. It sends corrupted parity, zero acknowledges and foreign frames. A framer that committed without a good acknowledge, or that replied to another device, would show a stray strobe or `reply_one`. Broadcast frames to the control register and to other registers, strap changes between frames, and mid-frame Start, reset and attention symbols check that the framer realigns itself and reports no error.

// File: rtl/swd_frame_pkg.sv
package swd_frame_pkg;
   typedef enum logic [2:0] {
      SYM_ZERO  = 3'd0,
      SYM_ONE   = 3'd1,
      SYM_START = 3'd2,
      SYM_ATTN  = 3'd3,
      SYM_RESET = 3'd4
   } sym_e;
endpackage

// File: rtl/swd_len_decode.sv
module swd_len_decode #(
   parameter int REG_W  = 6,
   parameter int NSHORT = 3,
   parameter logic [NSHORT*REG_W-1:0] SHORT_LIST = {6'h20, 6'h04, 6'h00}
) (
   input  logic [REG_W-1:0] reg_num,
   output logic             is_short
);
   logic [NSHORT-1:0] hit;

   if (NSHORT < 1) begin : g_bad_list
      $error("swd_len_decode: NSHORT must be at least 1");
   end

   for (genvar gi = 0; gi < NSHORT; gi++) begin : g_cmp
      assign hit[gi] = (reg_num == SHORT_LIST[gi*REG_W +: REG_W]);
   end

   assign is_short = |hit;
endmodule

// File: rtl/swd_shift.sv
module swd_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] q,
   output logic         msb
);
   if (W < 2) begin : g_bad_w
      $error("swd_shift: W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (clr)      q <= '0;
      else if (load)     q <= load_val;
      else if (shift_en) q <= {q[W-2:0], din};
   end

   assign msb = q[W-1];

   assert_load_shift_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift_en));
endmodule

// File: rtl/swd_parity_acc.sv
module swd_parity_acc (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic din,
   output logic par
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   par <= 1'b0;
      else if (clr) par <= 1'b0;
      else if (en)  par <= par ^ din;
   end

   assert_clr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !par);
endmodule

// File: rtl/swd_frame_slave.sv
module swd_frame_slave
   import swd_frame_pkg::*;
#(
   parameter int DEV_W    = 3,
   parameter int REG_W    = 6,
   parameter int DAT_W    = 16,
   parameter int SHORT_W  = 8,
   parameter int STRAP_W  = 2,
   parameter int NSHORT   = 3,
   parameter logic [NSHORT*REG_W-1:0] SHORT_LIST = {6'h20, 6'h04, 6'h00},
   parameter int CTRL_REG = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sym_valid,
   input  logic [2:0]         sym_code,
   input  logic [STRAP_W-1:0] strap,
   output logic [REG_W-1:0]   reg_addr,
   input  logic [DAT_W-1:0]   reg_rdata,
   output logic               reg_re,
   output logic               reg_we,
   output logic               reg_bcast,
   output logic [DAT_W-1:0]   reg_wdata,
   output logic               reply_one,
   output logic               bus_err
);
   localparam int P_REG = DEV_W;
   localparam int P_RW  = DEV_W + REG_W;
   localparam int P_DAT = P_RW + 1;
   localparam int MAXB  = P_DAT + DAT_W + 2;
   localparam int CNT_W = $clog2(MAXB + 1);
   localparam logic [CNT_W-1:0] C_DEVL = CNT_W'(P_REG - 1);
   localparam logic [CNT_W-1:0] C_REG  = CNT_W'(P_REG);
   localparam logic [CNT_W-1:0] C_RW   = CNT_W'(P_RW);
   localparam logic [CNT_W-1:0] C_DAT  = CNT_W'(P_DAT);
   localparam logic [REG_W-1:0] C_CTRL = REG_W'(CTRL_REG);

   if (SHORT_W < 1 || SHORT_W >= DAT_W) begin : g_bad_short
      $error("swd_frame_slave: SHORT_W must lie in 1..DAT_W-1");
   end
   if (STRAP_W >= DEV_W) begin : g_bad_strap
      $error("swd_frame_slave: straps plus one must fit the device number");
   end
   if (CTRL_REG >= (1 << REG_W)) begin : g_bad_ctrl
      $error("swd_frame_slave: CTRL_REG outside the register space");
   end

   logic             active, mine, bcast, is_rd;
   logic [CNT_W-1:0] cnt;
   logic [DEV_W-1:0] dev_sh, own;
   logic             we_q, err_q, bcast_q;
   logic [DAT_W-1:0] wdata_q;

   // symbol classification
   logic is_bit, b, take, got_start, got_reset;
   assign is_bit    = sym_valid && (sym_code == SYM_ZERO || sym_code == SYM_ONE);
   assign b         = (sym_code == SYM_ONE);
   assign take      = active && is_bit;
   assign got_start = sym_valid && (sym_code == SYM_START);
   assign got_reset = sym_valid && (sym_code == SYM_RESET);

   // field length from register number
   logic             is_short;
   logic [CNT_W-1:0] dlen, p_par, p_ack;
   swd_len_decode #(.REG_W(REG_W), .NSHORT(NSHORT), .SHORT_LIST(SHORT_LIST)) u_len (
      .reg_num (reg_addr),
      .is_short(is_short)
   );
   assign dlen  = is_short ? CNT_W'(SHORT_W) : CNT_W'(DAT_W);
   assign p_par = C_DAT + dlen;
   assign p_ack = p_par + CNT_W'(1);

   logic [DEV_W-1:0] dev_next;
   assign dev_next = {dev_sh[DEV_W-2:0], b};

   logic in_data;
   assign in_data = (cnt >= C_DAT) && (cnt < p_par);

   assign reg_re = take && (cnt == C_RW) && b && mine && !bcast;

   // shared data shifter: shifts in write data, shifts out read data
   logic [DAT_W-1:0] sh_q, load_val;
   logic             sh_msb;
   assign load_val = is_short ? {reg_rdata[SHORT_W-1:0], {(DAT_W-SHORT_W){1'b0}}}
                              : reg_rdata;
   swd_shift #(.W(DAT_W)) u_sh (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (got_start),
      .load    (reg_re),
      .load_val(load_val),
      .shift_en(take && in_data),
      .din     (b),
      .q       (sh_q),
      .msb     (sh_msb)
   );

   logic par;
   swd_parity_acc u_par (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (got_start),
      .en   (take && (cnt <= p_par)),
      .din  (b),
      .par  (par)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cnt      <= '0;
         dev_sh   <= '0;
         own      <= '0;
         mine     <= 1'b0;
         bcast    <= 1'b0;
         is_rd    <= 1'b0;
         reg_addr <= '0;
         we_q     <= 1'b0;
         err_q    <= 1'b0;
         bcast_q  <= 1'b0;
         wdata_q  <= '0;
      end else begin
         we_q  <= 1'b0;
         err_q <= 1'b0;
         if (got_start) begin
            active <= 1'b1;
            cnt    <= '0;
            own    <= DEV_W'(strap) + DEV_W'(1);
            mine   <= 1'b0;
            bcast  <= 1'b0;
            is_rd  <= 1'b0;
         end else if (got_reset) begin
            active <= 1'b0;
         end else if (take) begin
            cnt <= cnt + CNT_W'(1);
            if (cnt < C_REG) dev_sh <= dev_next;
            if (cnt == C_DEVL) begin
               mine  <= (dev_next == own) || (dev_next == '0);
               bcast <= (dev_next == '0);
            end
            if (cnt >= C_REG && cnt < C_RW) reg_addr <= {reg_addr[REG_W-2:0], b};
            if (cnt == C_RW) begin
               is_rd <= b;
               if (bcast && (b || reg_addr != C_CTRL)) mine <= 1'b0;
            end
            if (cnt == p_ack) begin
               active <= 1'b0;
               if (mine) begin
                  if (!is_rd) begin
                     if (!par && b) begin
                        we_q    <= 1'b1;
                        wdata_q <= sh_q;
                        bcast_q <= bcast;
                     end else begin
                        err_q <= 1'b1;
                     end
                  end else if (!b) begin
                     err_q <= 1'b1;
                  end
               end
            end
         end
      end
   end

   assign reply_one = active && mine && cnt > C_RW &&
                      (( is_rd && in_data && sh_msb) ||
                       ( is_rd && (cnt == p_par) && par) ||
                       (!is_rd && (cnt == p_ack) && !par));

   assign reg_we    = we_q;
   assign bus_err   = err_q;
   assign reg_bcast = bcast_q;
   assign reg_wdata = wdata_q;

   assert_we_err_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && bus_err));
   assert_we_after_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(sym_valid && sym_code == SYM_ONE));
   assert_err_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> $past(sym_valid));
   assert_bcast_ctrl_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_bcast) |-> (reg_addr == C_CTRL));
   assert_no_reply_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |=> !reply_one);
endmodule

// File: tb/sim_swd_frame_slave.sv
`timescale 1ns/100ps
module sim_swd_frame_slave;
   import swd_frame_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sym_valid = 1'b0;
   logic [2:0]  sym_code = 3'd0;
   logic [1:0]  strap = 2'd2;
   logic [5:0]  reg_addr;
   logic [15:0] reg_rdata;
   logic        reg_re, reg_we, reg_bcast, reply_one, bus_err;
   logic [15:0] reg_wdata;

   logic [15:0] rf [64];
   assign reg_rdata = rf[reg_addr];

   int total = 0;
   int bad = 0;
   logic mon_on = 1'b0;
   logic exp_re = 1'b0, exp_we = 1'b0, exp_err = 1'b0;

   always #2.5 clk = ~clk;

   swd_frame_slave u0 (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_code(sym_code),
      .strap(strap), .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_re(reg_re),
      .reg_we(reg_we), .reg_bcast(reg_bcast), .reg_wdata(reg_wdata),
      .reply_one(reply_one), .bus_err(bus_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // per-clock comparison against the bench model's expected strobes
   always @(negedge clk) begin
      if (mon_on) begin
         chk("R6 reg_re", {31'd0, reg_re}, {31'd0, exp_re});
         chk("R4 reg_we", {31'd0, reg_we}, {31'd0, exp_we});
         chk("R5 bus_err", {31'd0, bus_err}, {31'd0, exp_err});
      end
   end

   task automatic send_sym(input logic [2:0] c, input logic re_e, input logic we_e, input logic err_e);
      @(posedge clk); #1;
      sym_valid = 1'b1; sym_code = c; exp_re = re_e; exp_we = 1'b0; exp_err = 1'b0;
      @(posedge clk); #1;
      sym_valid = 1'b0; exp_re = 1'b0; exp_we = we_e; exp_err = err_e;
      @(posedge clk); #1;
      exp_we = 1'b0; exp_err = 1'b0;
   endtask

   task automatic quiet_bits(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         chk(tag, {31'd0, reply_one}, 32'd0);
         send_sym((i % 2) ? SYM_ONE : SYM_ZERO, 1'b0, 1'b0, 1'b0);
      end
   endtask

   // full frame; expectations derived from the requirements
   task automatic frame(input int dev, input int ra, input bit rd, input logic [15:0] d,
                        input bit bad_par, input bit ack0, input int attn_at, input string tag);
      bit bits[32];
      int L = 0;
      int own = int'(strap) + 1;
      bit sh = (ra == 0) || (ra == 4) || (ra == 32);
      int n = sh ? 8 : 16;
      bit bc = (dev == 0);
      bit mine = (dev == own) || (bc && !rd && ra == 5);
      logic [15:0] v;
      bit p = 1'b0;
      bit rep, ack_obs, we_e, err_e;
      v = rd ? (mine ? rf[ra] : 16'h0) : d;
      for (int i = 2; i >= 0; i--) bits[L++] = dev[i];
      for (int i = 5; i >= 0; i--) bits[L++] = ra[i];
      bits[L++] = rd;
      for (int i = n - 1; i >= 0; i--) bits[L++] = v[i];
      for (int i = 0; i < L; i++) p ^= bits[i];
      bits[L++] = p ^ (rd ? 1'b0 : bad_par);
      send_sym(SYM_START, 1'b0, 1'b0, 1'b0);
      for (int i = 0; i < L; i++) begin
         if (i == attn_at) send_sym(SYM_ATTN, 1'b0, 1'b0, 1'b0);
         rep = (mine && rd && i >= 10) ? bits[i] : 1'b0;
         chk({tag, " R6 reply_one"}, {31'd0, reply_one}, {31'd0, rep});
         send_sym(bits[i] ? SYM_ONE : SYM_ZERO, (i == 9) && mine && rd, 1'b0, 1'b0);
      end
      rep = !rd && mine && !bad_par;
      chk({tag, " R3 ack reply"}, {31'd0, reply_one}, {31'd0, rep});
      ack_obs = rd ? !ack0 : (rep && !ack0);
      we_e  = !rd && mine && !bad_par && !ack0;
      err_e = mine && (rd ? ack0 : (bad_par || ack0));
      send_sym(ack_obs ? SYM_ONE : SYM_ZERO, 1'b0, we_e, err_e);
      if (we_e) begin
         chk({tag, " R2 wdata"}, {16'd0, reg_wdata}, {16'd0, sh ? {8'd0, d[7:0]} : d});
         chk({tag, " R1 addr"}, {26'd0, reg_addr}, ra);
         chk({tag, " R8 bcast"}, {31'd0, reg_bcast}, {31'd0, bc});
      end
   endtask

   initial begin
      for (int i = 0; i < 64; i++) rf[i] = 16'(i * 16'h0911) ^ 16'h5A3C;
      repeat (3) @(posedge clk);
      #1;
      chk("R4 reset we", {31'd0, reg_we}, 32'd0);
      chk("R5 reset err", {31'd0, bus_err}, 32'd0);
      chk("R6 reset reply", {31'd0, reply_one}, 32'd0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      // own number = 3 with strap 2
      frame(3, 10, 0, 16'hBEEF, 0, 0, -1, "R1 w16");
      frame(3, 32, 0, 16'h125A, 0, 0, -1, "R2 w8");
      frame(3, 9,  1, 16'h0, 0, 0, -1, "R6 r16");
      frame(3, 4,  1, 16'h0, 0, 0, -1, "R2 r8a");
      frame(3, 0,  1, 16'h0, 0, 0, -1, "R2 r8b");
      frame(3, 17, 0, 16'h8001, 1, 0, -1, "R5 badpar");
      frame(3, 17, 0, 16'h8001, 0, 1, -1, "R5 ackzero");
      frame(3, 9,  1, 16'h0, 0, 1, -1, "R5 rdnak");
      frame(2, 10, 0, 16'h1234, 0, 0, -1, "R7 foreign w");
      frame(4, 9,  1, 16'h0, 0, 0, -1, "R7 foreign r");
      frame(3, 11, 0, 16'h7E81, 0, 0, -1, "R7 after foreign");
      frame(0, 9,  1, 16'h0, 0, 0, -1, "R8 bcast rd");
      frame(0, 5,  0, 16'h0003, 0, 0, -1, "R8 bcast ctrl");
      frame(0, 10, 0, 16'hFFFF, 0, 0, -1, "R8 bcast other");
      strap = 2'd0;
      frame(1, 12, 0, 16'hA5A5, 0, 0, -1, "R7 strap0");
      frame(3, 12, 0, 16'hA5A5, 0, 0, -1, "R7 old own");
      strap = 2'd3;
      frame(4, 20, 1, 16'h0, 0, 0, -1, "R7 strap3");
      // R9: mid-frame Start
      send_sym(SYM_START, 1'b0, 1'b0, 1'b0);
      quiet_bits(7, "R9 partial");
      frame(4, 14, 0, 16'h3C3C, 0, 0, -1, "R9 restart");
      // R9: reset symbol abandons the frame, data then ignored
      send_sym(SYM_START, 1'b0, 1'b0, 1'b0);
      quiet_bits(4, "R9 prereset");
      send_sym(SYM_RESET, 1'b0, 1'b0, 1'b0);
      quiet_bits(30, "R9 after reset");
      frame(4, 6, 0, 16'h0F0F, 0, 0, 12, "R9 attn write");
      frame(4, 9, 1, 16'h0, 0, 0, 15, "R9 attn read");
      // R10: excess bits after the acknowledge
      quiet_bits(5, "R10 excess");
      frame(4, 32, 1, 16'h0, 0, 0, -1, "R10 next");
      repeat (4) @(posedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(5 * 100000);
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule